// File: doc/BRIEF.md
# Zero-Crossing Volume Step Controller

This block holds the attenuation code actually applied to each channel of a stereo output stage and decides when that code may follow a new target written by software. The target code and two mode bits are shared by both channels. One bit turns off soft stepping and the other turns off zero-cross waiting. Each channel has its own zero-crossing pulse from an input detector. A one-microsecond tick sets the timing of a fixed window, 200 ticks by default.

The two mode bits select one of four update policies:
- Immediate: the applied code jumps to the target.
- Zero-cross jump: the applied code jumps on a crossing, or when the window runs out with no crossing.
- Timed ramp: the applied code moves one code per window.
- Zero-cross stepping: the applied code moves one code on the first crossing in a window, and a step is forced when the window ends without one.

A separate bypass input serves amplifier power sequencing and thermal shutdown. It applies the target on the next cycle, whatever the mode.

Top module: `vol_step_ctrl`

## Requirements
- R1: During and just after reset, every channel's applied code equals the parameter RST_ATT (all ones by default).
- R2: With both mode bits high (soft_off=1, zc_off=1), the applied code of each channel equals the target one clock after the target is presented.
- R3: While bypass_now is high, each channel's applied code takes the target on the next clock, in every mode.
- R4: In zero-cross jump mode (soft_off=1, zc_off=0), a channel jumps to the target on the clock after its own zc_pulse bit (bit 0 left, bit 1 right). The other channel is not affected.
- R5: In zero-cross jump mode, a channel that sees no crossing takes the target on the clock edge that samples the WIN_TICKS-th tick counted since its window began.
- R6: In timed ramp mode (soft_off=0, zc_off=1), the applied code moves by exactly one code toward the target on each window expiry and never moves away from it.
- R7: In zero-cross stepping mode (soft_off=0, zc_off=0), the first crossing inside a window moves the code by one. Further crossings are ignored until that window expires.
- R8: In zero-cross stepping mode, a window that expires with no crossing accepted forces one step.
- R9: When a channel's applied code equals the target, it holds and its window counter is cleared.
- R10: A channel's window restarts from zero after an expiry and after a jump, so the next timed step comes a full WIN_TICKS ticks later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tgt_att | input | ATT_W | Target attenuation code shared by all channels |
| soft_off | input | 1 | High disables soft stepping |
| zc_off | input | 1 | High disables zero-cross waiting |
| bypass_now | input | 1 | Apply the target at once (power sequencing, thermal shutdown) |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| zc_pulse | input | NCH | Per-channel zero-crossing pulse, bit 0 left |
| att_q | output | NCH*ATT_W | Applied codes, channel n in bits [n*ATT_W +: ATT_W] |

## Verification
Every cycle, assertions check four things. Immediate mode and bypass land exactly on the target. Stepping modes never move more than one code per clock. The code never moves away from the target while below it. A code equal to the target never changes. They also check that a crossing seen after one was already taken in the window causes no step, and that the window counter never passes its last value. The exact timing needs the bench scenarios: a step falling on the tenth tick, two steps a full window apart, one channel jumping while the other waits, and a forced step on the channel that saw no crossing. The bench compares every cycle against a reference model built from the requirements, under random mode changes, ticks and crossings.

// File: rtl/vsc_pkg.sv
package vsc_pkg;

   typedef enum logic [1:0] {
      MODE_IMMED   = 2'd0,
      MODE_ZC_JUMP = 2'd1,
      MODE_RAMP    = 2'd2,
      MODE_ZC_STEP = 2'd3
   } vmode_e;

   function automatic vmode_e decode_mode(input logic soft_off, input logic zc_off);
      case ({soft_off, zc_off})
         2'b11:   return MODE_IMMED;
         2'b10:   return MODE_ZC_JUMP;
         2'b01:   return MODE_RAMP;
         default: return MODE_ZC_STEP;
      endcase
   endfunction

endpackage

// File: rtl/vsc_window.sv
module vsc_window #(
   parameter int WIN_TICKS = 200
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic tick,
   output logic expire
);
   localparam int CNT_W = (WIN_TICKS > 2) ? $clog2(WIN_TICKS) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(WIN_TICKS - 1);

   logic [CNT_W-1:0] cnt_q;

   assign expire = tick && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clr || expire)
         cnt_q <= '0;
      else if (tick)
         cnt_q <= cnt_q + 1'b1;
   end

   // R10
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST);

   // R10
   win_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (expire || clr) |=> (cnt_q == '0));

endmodule

// File: rtl/vsc_chan.sv
module vsc_chan
   import vsc_pkg::*;
#(
   parameter int               ATT_W     = 6,
   parameter int               WIN_TICKS = 200,
   parameter logic [ATT_W-1:0] RST_ATT   = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [ATT_W-1:0] tgt,
   input  vmode_e           mode,
   input  logic             bypass,
   input  logic             zc,
   input  logic             tick,
   output logic [ATT_W-1:0] applied
);
   logic [ATT_W-1:0] app_q, app_n, step_v;
   logic             tk_q, tk_n;
   logic             clr, expire, at_tgt;

   vsc_window #(.WIN_TICKS(WIN_TICKS)) u_win (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (clr),
      .tick   (tick),
      .expire (expire)
   );

   assign at_tgt = (app_q == tgt);
   assign step_v = (tgt > app_q) ? app_q + 1'b1 : app_q - 1'b1;

   always_comb begin
      app_n = app_q;
      tk_n  = tk_q;
      clr   = 1'b0;
      if (bypass || mode == MODE_IMMED) begin
         app_n = tgt;
         tk_n  = 1'b0;
         clr   = 1'b1;
      end else if (at_tgt) begin
         tk_n = 1'b0;
         clr  = 1'b1;
      end else begin
         case (mode)
            MODE_ZC_JUMP: begin
               if (zc) begin
                  app_n = tgt;
                  clr   = 1'b1;
               end else if (expire) begin
                  app_n = tgt;
               end
            end
            MODE_RAMP: begin
               if (expire) app_n = step_v;
            end
            MODE_ZC_STEP: begin
               if (expire) begin
                  if (!tk_q) app_n = step_v;
                  tk_n = 1'b0;
               end else if (zc && !tk_q) begin
                  app_n = step_v;
                  tk_n  = 1'b1;
               end
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         app_q <= RST_ATT;
         tk_q  <= 1'b0;
      end else begin
         app_q <= app_n;
         tk_q  <= tk_n;
      end
   end

   assign applied = app_q;

   // R2 R3
   imm_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mode) == MODE_IMMED || $past(bypass)) |-> applied == $past(tgt));

   // R6
   unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(mode) == MODE_RAMP || $past(mode) == MODE_ZC_STEP) && !$past(bypass))
      |-> (applied == $past(applied) || applied == $past(applied) + 1'b1
           || applied == $past(applied) - 1'b1));

   // R6
   toward_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(applied) < $past(tgt)) |-> applied >= $past(applied));

   // R9
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(applied == tgt) |-> applied == $past(applied));

   // R7
   one_per_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tk_q && zc && !expire && !bypass && mode == MODE_ZC_STEP)
      |=> applied == $past(applied));

endmodule

// File: rtl/vol_step_ctrl.sv
module vol_step_ctrl
   import vsc_pkg::*;
#(
   parameter int               NCH       = 2,
   parameter int               ATT_W     = 6,
   parameter int               WIN_TICKS = 200,
   parameter logic [ATT_W-1:0] RST_ATT   = '1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ATT_W-1:0]     tgt_att,
   input  logic                 soft_off,
   input  logic                 zc_off,
   input  logic                 bypass_now,
   input  logic                 us_tick,
   input  logic [NCH-1:0]       zc_pulse,
   output logic [NCH*ATT_W-1:0] att_q
);
   generate
      if (NCH < 1) begin : g_bad_nch
         $error("NCH must be at least 1");
      end
      if (ATT_W < 2) begin : g_bad_w
         $error("ATT_W must be at least 2");
      end
      if (WIN_TICKS < 2) begin : g_bad_win
         $error("WIN_TICKS must be at least 2");
      end
   endgenerate

   vmode_e mode;
   assign mode = decode_mode(soft_off, zc_off);

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      vsc_chan #(
         .ATT_W     (ATT_W),
         .WIN_TICKS (WIN_TICKS),
         .RST_ATT   (RST_ATT)
      ) u_chan (
         .clk     (clk),
         .rst_n   (rst_n),
         .tgt     (tgt_att),
         .mode    (mode),
         .bypass  (bypass_now),
         .zc      (zc_pulse[c]),
         .tick    (us_tick),
         .applied (att_q[c*ATT_W +: ATT_W])
      );
   end

endmodule

// File: tb/sim_vol_step_ctrl.sv
module sim_vol_step_ctrl;
   localparam int CLK_P = 10;
   localparam int W     = 6;
   localparam int WIN   = 10;
   localparam int NCH   = 2;
   localparam int RST_V = 63;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [W-1:0]   tgt_att = '0;
   logic           soft_off = 1'b1, zc_off = 1'b1, bypass_now = 1'b0, us_tick = 1'b0;
   logic [NCH-1:0] zc_pulse = '0;
   logic [NCH*W-1:0] att_q;

   int n_chk = 0, n_fail = 0;
   bit done = 0;
   int m_app [NCH];
   int m_cnt [NCH];
   bit m_tk  [NCH];

   always #(CLK_P/2) clk = ~clk;

   vol_step_ctrl #(.NCH(NCH), .ATT_W(W), .WIN_TICKS(WIN)) u0 (
      .clk(clk), .rst_n(rst_n), .tgt_att(tgt_att), .soft_off(soft_off),
      .zc_off(zc_off), .bypass_now(bypass_now), .us_tick(us_tick),
      .zc_pulse(zc_pulse), .att_q(att_q)
   );

   function automatic int out_of(int ch);
      return int'(att_q[ch*W +: W]);
   endfunction

   task automatic check(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   // reference model, advanced with the inputs sampled at the coming edge
   task automatic model_adv();
      for (int c = 0; c < NCH; c++) begin
         int t, stp, nc;
         bit ex;
         t = int'(tgt_att);
         if (bypass_now || (soft_off && zc_off)) begin
            m_app[c] = t; m_cnt[c] = 0; m_tk[c] = 0;
         end else if (m_app[c] == t) begin
            m_cnt[c] = 0; m_tk[c] = 0;
         end else begin
            ex  = us_tick && (m_cnt[c] == WIN-1);
            nc  = ex ? 0 : (us_tick ? m_cnt[c] + 1 : m_cnt[c]);
            stp = (m_app[c] < t) ? m_app[c] + 1 : m_app[c] - 1;
            if (soft_off) begin
               if (zc_pulse[c] || ex) begin m_app[c] = t; nc = 0; end
            end else if (zc_off) begin
               if (ex) m_app[c] = stp;
            end else begin
               if (ex) begin
                  if (!m_tk[c]) m_app[c] = stp;
                  m_tk[c] = 0;
               end else if (zc_pulse[c] && !m_tk[c]) begin
                  m_app[c] = stp; m_tk[c] = 1;
               end
            end
            m_cnt[c] = nc;
         end
      end
   endtask

   task automatic cyc(string tag);
      model_adv();
      @(negedge clk);
      for (int c = 0; c < NCH; c++) check(tag, out_of(c), m_app[c]);
   endtask

   task automatic run(int n, string tag, bit tick_every);
      for (int i = 0; i < n; i++) begin
         us_tick = tick_every ? 1'b1 : ~us_tick;
         cyc(tag);
      end
   endtask

   task automatic set_mode(bit s, bit z);
      soft_off = s; zc_off = z;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: got hang expected finish");
      finish_run();
   end

   initial begin
      int seed, base;
      seed = 32'h5eed1234;
      void'($urandom(seed));
      for (int c = 0; c < NCH; c++) begin m_app[c] = RST_V; m_cnt[c] = 0; m_tk[c] = 0; end
      set_mode(1, 0); tgt_att = 6'd10;
      repeat (3) @(negedge clk);
      for (int c = 0; c < NCH; c++) check("R1 reset", out_of(c), RST_V);
      rst_n = 1'b1;
      check("R1 after release", out_of(0), RST_V);

      // R2 immediate
      set_mode(1, 1); tgt_att = 6'd20; us_tick = 0;
      cyc("R2");
      check("R2 left", out_of(0), 20);
      tgt_att = 6'd3; cyc("R2");
      check("R2 right", out_of(1), 3);

      // R6 / R10: timed ramp, tick every cycle, step on every tenth cycle
      set_mode(0, 1); tgt_att = 6'd6; us_tick = 1;
      for (int i = 1; i <= 20; i++) begin
         cyc("R10");
         if (i == 9)  check("R10 no early step", out_of(0), 3);
         if (i == 10) check("R6 first step", out_of(0), 4);
         if (i == 19) check("R10 full window", out_of(0), 4);
         if (i == 20) check("R6 second step", out_of(1), 5);
      end
      run(30, "R6", 1);
      check("R9 reached", out_of(0), 6);
      run(15, "R9", 1);
      check("R9 held", out_of(1), 6);

      // R3 bypass while ramping
      tgt_att = 6'd30; run(3, "R3", 1);
      bypass_now = 1; cyc("R3"); bypass_now = 0;
      check("R3 bypass", out_of(0), 30);

      // R4 / R5 zero-cross jump
      set_mode(1, 0); tgt_att = 6'd40; us_tick = 0;
      cyc("R4"); cyc("R4");
      zc_pulse = 2'b01; cyc("R4"); zc_pulse = 2'b00;
      check("R4 left jumped", out_of(0), 40);
      check("R4 right waits", out_of(1), 30);
      run(40, "R5", 0);
      check("R5 timeout", out_of(1), 40);

      // R7 / R8 zero-cross stepping
      set_mode(0, 0); tgt_att = 6'd45; us_tick = 0;
      cyc("R7");
      zc_pulse = 2'b01; cyc("R7"); zc_pulse = 2'b00;
      check("R7 first crossing", out_of(0), 41);
      cyc("R7"); cyc("R7");
      zc_pulse = 2'b01; cyc("R7"); zc_pulse = 2'b00;
      check("R7 second ignored", out_of(0), 41);
      check("R8 right pending", out_of(1), 40);
      run(120, "R8", 0);
      check("R8 forced steps", out_of(1), 45);

      // random mixture
      base = 0;
      for (int i = 0; i < 4000; i++) begin
         if ($urandom_range(0, 99) < 3) set_mode(1'($urandom), 1'($urandom));
         if ($urandom_range(0, 99) < 2) tgt_att = W'($urandom);
         bypass_now = ($urandom_range(0, 99) < 1);
         us_tick = 1'($urandom);
         zc_pulse = ($urandom_range(0, 99) < 10) ? NCH'($urandom) : '0;
         cyc("R10 random");
         base++;
      end
      bypass_now = 0; zc_pulse = '0;
      finish_run();
   end
endmodule